// File: doc/BRIEF.md
# Serial Gain-Word Control Interface

This block is the digital front end of a programmable logarithmic gain stage. A host writes a 9-bit gain word over a three-wire serial port: a shift clock, a data line and a commit strobe. Bits enter a shift register and take effect only when the commit strobe copies them into a separate holding latch. The current setting therefore stays in force while the next word is shifted in.

A second strobe copies the holding latch back into the shift register. The stored word can then be clocked out on the serial output. Because that output is the far end of the shift register, several units can be chained. Each serial output feeds the next unit's serial input, and one shared commit strobe applies a long frame to every unit at once.

A mode input chooses the source of the gain setting: the holding latch, or nine directly driven select inputs. The selected word is reported both raw and as a signed gain in tenths of a dB. A powerdown level is passed on to the analog section. All serial pins are sampled on a faster system clock through two-flop synchronizers. The system clock must run at least four times faster than the fastest shift-clock toggle.

Top module: `gain_word_serial_ctrl`

## Requirements
- R1: After reset the shift register and the holding latch are all zeros. The gain word output is 0, the gain in tenths is 0, and the serial output, powerdown flag and error pulse are all low.
- R2: The serial data bit is sampled on each rising shift-clock edge. The register advances on each falling edge, and the first bit clocked in becomes word bit 0. In the word, bits 3:0 are the fine code with its LSB at bit 0, bits 7:4 are the coarse code with its LSB at bit 4, and bit 8 selects attenuation (1) or gain (0).
- R3: While the commit strobe is high and the shift clock is low, the shift register is copied into the holding latch. Shifting without a commit leaves the active setting unchanged.
- R4: While the readback strobe is high and the shift clock is low, the holding latch is copied into the shift register. The serial output then shows word bit 0 at once, and each later falling edge of the shift clock presents the next bit.
- R5: With the mode input at 1 the holding latch drives the gain, and the parallel select inputs have no effect. With the mode input at 0 the parallel inputs, in the same bit layout, drive the gain.
- R6: The gain in tenths of a dB is 15·coarse + fine, negated when bit 8 is 1. This gives a range of −240 to +240, and word 9'h100 reports 0.
- R7: The powerdown flag follows the powerdown input. Powerdown neither clears nor alters the holding latch, and serial loading keeps working while it is asserted.
- R8: When the commit strobe and the readback strobe are both high in the same cycle, the commit takes place and the readback copy is ignored.
- R9: A strobe that arrives while the shift clock is high is ignored. Each such occurrence raises exactly one one-cycle error pulse.
- R10: With two units chained, an 18-bit frame followed by one shared commit applies the first 9 bits to the downstream unit and the last 9 bits to the upstream unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock |
| sdin_i | input | 1 | Serial data in |
| commit_i | input | 1 | Strobe that copies the shift register into the holding latch |
| rdbk_i | input | 1 | Strobe that copies the holding latch into the shift register |
| ser_mode_i | input | 1 | 1 selects the holding latch, 0 selects the parallel inputs |
| par_word_i | input | 9 | Parallel gain-select inputs |
| pwrdn_i | input | 1 | Powerdown request |
| sdout_o | output | 1 | Serial data out (end of the shift register) |
| gain_word_o | output | 9 | Selected gain word |
| gain_tenths_o | output | 9 | Signed gain in tenths of a dB |
| pwrdn_o | output | 1 | Powerdown flag for the analog section |
| proto_err_o | output | 1 | One-cycle pulse when a strobe arrives while the shift clock is high |

## Verification
The commit strobe and the readback strobe can both be high in one cycle. The bench provokes this by shifting in a word that differs from the latched one and then raising both strobes together for several cycles with the shift clock low. The case is judged at the gain output: it must show the newly shifted word, which could not happen if the readback copy had overwritten the shift register first. A second collision, a strobe during a high shift-clock phase, is judged by the unchanged gain and by a count of exactly one error pulse.

// File: rtl/gwsc_pkg.sv
package gwsc_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_COMMIT = 2'd1,
      ACT_READ = 2'd2
   } gwsc_act_e;

   function automatic int gwsc_max_tenths(input int fine_w, input int coarse_w, input int step);
      return step * ((1 << coarse_w) - 1) + ((1 << fine_w) - 1);
   endfunction

endpackage

// File: rtl/gwsc_sync.sv
module gwsc_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gwsc_sync needs at least two stages");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/gwsc_shift.sv
module gwsc_shift
   import gwsc_pkg::*;
#(
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic              commit_s,
   input  logic              rdbk_s,
   output logic              sr_tail,
   output logic [WORD_W-1:0] latch_q,
   output logic              proto_err
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("gwsc_shift needs a word of at least two bits");
      end
   endgenerate

   logic              sclk_p;
   logic              cap_q;
   logic [WORD_W-1:0] sr_q;
   logic              err_prev;
   logic              err_q;

   logic      rise;
   logic      fall;
   logic      sclk_low;
   logic      err_cond;
   gwsc_act_e act;

   assign rise     = sclk_s & ~sclk_p;
   assign fall     = ~sclk_s & sclk_p;
   assign sclk_low = ~sclk_s & ~sclk_p;
   assign err_cond = (commit_s | rdbk_s) & sclk_s;

   always_comb begin
      act = ACT_NONE;
      if (sclk_low) begin
         if (commit_s)    act = ACT_COMMIT;
         else if (rdbk_s) act = ACT_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p   <= 1'b0;
         cap_q    <= 1'b0;
         sr_q     <= '0;
         latch_q  <= '0;
         err_prev <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         sclk_p   <= sclk_s;
         err_prev <= err_cond;
         err_q    <= err_cond & ~err_prev;
         if (rise) cap_q <= din_s;
         if (act == ACT_READ)  sr_q <= latch_q;
         else if (fall)        sr_q <= {cap_q, sr_q[WORD_W-1:1]};
         if (act == ACT_COMMIT) latch_q <= sr_q;
      end
   end

   assign sr_tail   = sr_q[0];
   assign proto_err = err_q;

   // R3: the active setting moves only on a commit
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act != ACT_COMMIT) |=> $stable(latch_q));

   // R8: both strobes together leave the shift register untouched and commit it
   p_commit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_s && rdbk_s && sclk_low) |=> (latch_q == $past(sr_q)) && $stable(sr_q));

   // R9: a strobe during a high shift clock has no effect on the latch
   p_high_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_cond |=> $stable(latch_q));

   // R9: the error indication lasts one cycle
   p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> !err_q);
endmodule

// File: rtl/gwsc_gain_map.sv
module gwsc_gain_map
   import gwsc_pkg::*;
#(
   parameter int FINE_W      = 4,
   parameter int COARSE_W    = 4,
   parameter int COARSE_STEP = 15,
   parameter int GAIN_W      = 9,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [FINE_W+COARSE_W:0] word_i,
   output logic [FINE_W+COARSE_W:0] word_o,
   output logic [GAIN_W-1:0]        tenths_o
);
   localparam int WORD_W = FINE_W + COARSE_W + 1;
   localparam int MAX_T  = gwsc_max_tenths(FINE_W, COARSE_W, COARSE_STEP);

   generate
      if ((1 << (GAIN_W - 1)) <= MAX_T) begin : g_bad_gain_w
         $error("gwsc_gain_map gain width too small");
      end
   endgenerate

   logic [FINE_W-1:0]   fine;
   logic [COARSE_W-1:0] coarse;
   logic                atten;
   logic [GAIN_W-1:0]   mag;
   logic [GAIN_W-1:0]   tenths_n;

   assign fine     = word_i[FINE_W-1:0];
   assign coarse   = word_i[FINE_W +: COARSE_W];
   assign atten    = word_i[WORD_W-1];
   assign mag      = GAIN_W'(COARSE_STEP) * GAIN_W'(coarse) + GAIN_W'(fine);
   assign tenths_n = atten ? (~mag + GAIN_W'(1)) : mag;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_o   <= '0;
               tenths_o <= '0;
            end else begin
               word_o   <= word_i;
               tenths_o <= tenths_n;
            end
         end
      end else begin : g_comb
         assign word_o   = word_i;
         assign tenths_o = tenths_n;
      end
   endgenerate

   // R6: reported gain stays within the coded range
   p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(tenths_o) <= MAX_T) && ($signed(tenths_o) >= -MAX_T));

   // R6: attenuation never reports a positive value, gain never a negative one
   p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_o[WORD_W-1] ? ($signed(tenths_o) <= 0) : ($signed(tenths_o) >= 0));
endmodule

// File: rtl/gain_word_serial_ctrl.sv
module gain_word_serial_ctrl
   import gwsc_pkg::*;
#(
   parameter int FINE_W      = 4,
   parameter int COARSE_W    = 4,
   parameter int COARSE_STEP = 15,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W     = FINE_W + COARSE_W + 1,
   localparam int MAX_T      = gwsc_max_tenths(FINE_W, COARSE_W, COARSE_STEP),
   localparam int GAIN_W     = $clog2(MAX_T + 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic              commit_i,
   input  logic              rdbk_i,
   input  logic              ser_mode_i,
   input  logic [WORD_W-1:0] par_word_i,
   input  logic              pwrdn_i,
   output logic              sdout_o,
   output logic [WORD_W-1:0] gain_word_o,
   output logic [GAIN_W-1:0] gain_tenths_o,
   output logic              pwrdn_o,
   output logic              proto_err_o
);
   logic [3:0]        sync_q;
   logic              mode_q;
   logic [WORD_W-1:0] par_q;
   logic [WORD_W-1:0] latch_w;
   logic [WORD_W-1:0] sel_word;

   gwsc_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk_i, sdin_i, commit_i, rdbk_i}),
      .q     (sync_q)
   );

   gwsc_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sync_q[3]),
      .din_s     (sync_q[2]),
      .commit_s  (sync_q[1]),
      .rdbk_s    (sync_q[0]),
      .sr_tail   (sdout_o),
      .latch_q   (latch_w),
      .proto_err (proto_err_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b1;
         par_q   <= '0;
         pwrdn_o <= 1'b0;
      end else begin
         mode_q  <= ser_mode_i;
         par_q   <= par_word_i;
         pwrdn_o <= pwrdn_i;
      end
   end

   assign sel_word = mode_q ? latch_w : par_q;

   gwsc_gain_map #(
      .FINE_W      (FINE_W),
      .COARSE_W    (COARSE_W),
      .COARSE_STEP (COARSE_STEP),
      .GAIN_W      (GAIN_W),
      .REG_OUT     (1'b1)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_i   (sel_word),
      .word_o   (gain_word_o),
      .tenths_o (gain_tenths_o)
   );

   // R5: in serial mode a steady latch keeps the output steady whatever the parallel pins do
   p_serial_ignores_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && $stable(latch_w) && $stable(mode_q)) |=> $stable(gain_word_o));

   // R7: the powerdown flag is a one-cycle image of the request
   p_pwrdn_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pwrdn_o == $past(pwrdn_i)));
endmodule

// File: tb/gain_word_serial_ctrl_test.sv
module gain_word_serial_ctrl_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, sclk, sdin, commit, rdbk, ser_mode, pwrdn;
   logic [8:0] par_word;
   logic       sdout, pwrdn_o, perr;
   logic [8:0] gword;
   logic [8:0] gtenths;
   logic       sdout2, pwrdn2, perr2;
   logic [8:0] gword2;
   logic [8:0] gtenths2;

   gain_word_serial_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .commit_i(commit),
      .rdbk_i(rdbk), .ser_mode_i(ser_mode), .par_word_i(par_word), .pwrdn_i(pwrdn),
      .sdout_o(sdout), .gain_word_o(gword), .gain_tenths_o(gtenths),
      .pwrdn_o(pwrdn_o), .proto_err_o(perr));

   gain_word_serial_ctrl uut2 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdout), .commit_i(commit),
      .rdbk_i(rdbk), .ser_mode_i(ser_mode), .par_word_i(par_word), .pwrdn_i(pwrdn),
      .sdout_o(sdout2), .gain_word_o(gword2), .gain_tenths_o(gtenths2),
      .pwrdn_o(pwrdn2), .proto_err_o(perr2));

   int n_chk = 0;
   int n_fail = 0;
   int n_err_pulses = 0;
   bit finished = 0;

   logic [8:0] q_word[$];
   int         q_unit[$];
   string      q_tag[$];
   event       chk_ev;

   always @(posedge clk) if (rst_n && perr) n_err_pulses <= n_err_pulses + 1;

   function automatic int exp_tenths(input logic [8:0] w);
      int m;
      m = 15 * int'(w[7:4]) + int'(w[3:0]);
      return w[8] ? -m : m;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(input int unit, input logic [8:0] w, input string tag);
      q_word.push_back(w);
      q_unit.push_back(unit);
      q_tag.push_back(tag);
      ->chk_ev;
      wait_clk(2);
   endtask

   initial begin : monitor
      forever begin
         logic [8:0] w;
         int u;
         string t;
         int act_t;
         @(chk_ev);
         @(negedge clk);
         w = q_word.pop_front();
         u = q_unit.pop_front();
         t = q_tag.pop_front();
         if (u == 0) begin
            act_t = int'($signed(gtenths));
            check(gword == w, {t, " word"}, int'(gword), int'(w));
         end else begin
            act_t = int'($signed(gtenths2));
            check(gword2 == w, {t, " word"}, int'(gword2), int'(w));
         end
         check(act_t == exp_tenths(w), {t, " tenths"}, act_t, exp_tenths(w));
      end
   end

   task automatic send_bit(input logic b);
      sdin = b;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
   endtask

   task automatic send_word(input logic [8:0] w);
      for (int i = 0; i < 9; i++) send_bit(w[i]);
      wait_clk(4);
   endtask

   task automatic pulse_commit;
      commit = 1'b1;
      wait_clk(4);
      commit = 1'b0;
      wait_clk(6);
   endtask

   task automatic read_word(output logic [8:0] r);
      sdin = 1'b0;
      rdbk = 1'b1;
      wait_clk(4);
      rdbk = 1'b0;
      wait_clk(4);
      r[0] = sdout;
      for (int k = 1; k < 9; k++) begin
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(4);
         r[k] = sdout;
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : driver
      logic [8:0] rb;
      logic [17:0] frame;
      int e0;
      rst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; commit = 1'b0; rdbk = 1'b0;
      ser_mode = 1'b1; par_word = 9'h000; pwrdn = 1'b0;
      wait_clk(5);
      check(gword == 9'h000, "R1 word in reset", int'(gword), 0);
      check(sdout == 1'b0 && perr == 1'b0 && pwrdn_o == 1'b0, "R1 outputs low in reset",
            int'({sdout, perr, pwrdn_o}), 0);
      rst_n = 1'b1;
      wait_clk(3);
      push_exp(0, 9'h000, "R1 after reset");

      // R2 bit order and fields, R3 no effect before commit
      send_word(9'h1A5);
      push_exp(0, 9'h000, "R3 shift without commit");
      pulse_commit();
      push_exp(0, 9'h1A5, "R2 serial word");

      // R3 active setting held while the next word shifts in
      send_word(9'h0F0);
      push_exp(0, 9'h1A5, "R3 hold");
      pulse_commit();
      push_exp(0, 9'h0F0, "R6 coarse max");

      // R4 readback
      read_word(rb);
      check(rb == 9'h0F0, "R4 readback word", int'(rb), 'h0F0);
      push_exp(0, 9'h0F0, "R4 setting after readback");

      // R5 mode selection
      par_word = 9'h1FF;
      wait_clk(4);
      push_exp(0, 9'h0F0, "R5 parallel ignored in serial mode");
      ser_mode = 1'b0;
      wait_clk(4);
      push_exp(0, 9'h1FF, "R5 parallel full attenuation");
      par_word = 9'h0FF;
      wait_clk(4);
      push_exp(0, 9'h0FF, "R5 parallel full gain");
      par_word = 9'h100;
      wait_clk(4);
      push_exp(0, 9'h100, "R6 attenuate zero");
      ser_mode = 1'b1;
      wait_clk(4);
      push_exp(0, 9'h0F0, "R5 back to latch");

      // R7 powerdown
      pwrdn = 1'b1;
      wait_clk(4);
      check(pwrdn_o == 1'b1, "R7 flag set", int'(pwrdn_o), 1);
      push_exp(0, 9'h0F0, "R7 latch kept");
      send_word(9'h00F);
      pulse_commit();
      push_exp(0, 9'h00F, "R7 loading while powered down");
      pwrdn = 1'b0;
      wait_clk(4);
      check(pwrdn_o == 1'b0, "R7 flag clear", int'(pwrdn_o), 0);
      push_exp(0, 9'h00F, "R7 latch kept after wake");

      // R8 both strobes together
      send_word(9'h133);
      commit = 1'b1;
      rdbk = 1'b1;
      wait_clk(4);
      commit = 1'b0;
      rdbk = 1'b0;
      wait_clk(6);
      push_exp(0, 9'h133, "R8 commit wins");

      // R9 strobe while shift clock high
      send_word(9'h055);
      e0 = n_err_pulses;
      sclk = 1'b1;
      wait_clk(4);
      commit = 1'b1;
      wait_clk(4);
      commit = 1'b0;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(6);
      push_exp(0, 9'h133, "R9 strobe ignored");
      check(n_err_pulses == e0 + 1, "R9 one error pulse", n_err_pulses - e0, 1);

      // R10 two chained units
      frame = {9'h10A, 9'h0C7};
      for (int i = 0; i < 18; i++) send_bit(frame[i]);
      wait_clk(4);
      pulse_commit();
      push_exp(0, 9'h10A, "R10 upstream unit");
      push_exp(1, 9'h0C7, "R10 downstream unit");

      wait_clk(4);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule